// File: doc/BRIEF.md
# UART FIFO Trigger and Interrupt Controller

This block holds the FIFO control settings of one UART channel and turns the fill counts of the channel's transmit and receive FIFOs into two interrupt requests. A host write to the control register sets the FIFO enable, requests a pointer reset for either FIFO, stores a legacy DMA mode bit and selects a trigger level for each direction. A separate write picks one of four trigger tables. Both directions share that table, and the most recent table write applies to both.

The FIFO storage itself lies outside the block. The block only sees the two fill counts and answers a reset request with a one-cycle strobe to the pointer and counter logic of the affected FIFO. The receive interrupt follows the receive count against its level. The transmit interrupt fires when the count drops below its level after having been above it. If the last reload never rose above the level, it waits until the FIFO is empty.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, the trigger table is 0, both pointer-reset strobes are low, the receive interrupt is low with a zero receive count, and the transmit interrupt is high with a zero transmit count.
- R2: The control readback shows enable on bit 0, receive reset on bit 1, transmit reset on bit 2, DMA mode on bit 3, the transmit select on bits 5:4 and the receive select on bits 7:6. Writes store enable and both selects unconditionally.
- R3: A control write with bit 0 = 1 and bit 2 = 1 drives `tx_ptr_rst` high for exactly the following cycle. Readback bit 2 is 1 only during that cycle. With bit 0 = 0 no strobe occurs.
- R4: A control write with bit 0 = 1 and bit 1 = 1 drives `rx_ptr_rst` high for exactly the following cycle and leaves `tx_ptr_rst` low. With bit 0 = 0 no strobe occurs.
- R5: The DMA mode bit is taken only from writes that have bit 0 = 1. Other writes leave the stored bit, as seen on readback bit 3, unchanged. It drives no output.
- R6: With enable = 1, the trigger level for select values 0..3 is {1,4,8,14} in table 0, {8,16,24,28} in table 1, {8,16,32,56} in table 2 and {1,16,32,56} in table 3. The table index is the 2-bit value written through `tbl_wr`.
- R7: One table index governs both directions, and each table write replaces it at once for both.
- R8: With enable = 0 the trigger level of both directions is one character, whatever the selects and the table.
- R9: `rx_irq` is high exactly while the receive count is at or above the receive trigger level.
- R10: `tx_irq` is high whenever the transmit count is 0. After the count has been above the transmit level, `tx_irq` is high while the count is below that level.
- R11: If the count has not risen above the transmit level since the FIFO was last empty or last pointer-reset, `tx_irq` stays low for any nonzero count. A transmit pointer-reset strobe clears the above-level record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| tbl_wr | input | 1 | Write strobe for the trigger table index |
| tbl_wdata | input | 2 | Trigger table index |
| tx_count | input | CNT_W (7) | Current transmit FIFO fill count |
| rx_count | input | CNT_W (7) | Current receive FIFO fill count |
| tx_ptr_rst | output | 1 | One-cycle reset strobe for transmit FIFO pointers and count |
| rx_ptr_rst | output | 1 | One-cycle reset strobe for receive FIFO pointers and count |
| tx_irq | output | 1 | Transmit trigger interrupt |
| rx_irq | output | 1 | Receive trigger interrupt |

## Verification
The hardest state to reach is a transmit pointer reset that lands while the above-level record is set. It must then be shown that the record was cleared and was not left for the refill to inherit. The stimulus first fills the transmit count above the level. It then issues the reset write and drops the count to a nonzero value below the level in the same cycle the strobe appears. It then checks that the interrupt stays low, which it would not do if the record survived. The receive side needs every table and select combination, so each of the sixteen levels is probed one count below and at the level.

// File: rtl/uft_pkg.sv
package uft_pkg;

   localparam int unsigned NUM_TABLES = 4;
   localparam int unsigned MAX_LEVEL  = 56;

   // Trigger level for a table index and a per-direction select
   function automatic int unsigned trig_level(input logic [1:0] tbl, input logic [1:0] sel);
      int unsigned lvl;
      unique case (tbl)
         2'd0: lvl = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 4  : (sel == 2'd2) ? 8  : 14;
         2'd1: lvl = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : (sel == 2'd2) ? 24 : 28;
         2'd2: lvl = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : (sel == 2'd2) ? 32 : 56;
         default: lvl = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : (sel == 2'd2) ? 32 : 56;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/uft_ctl_reg.sv
module uft_ctl_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_wdata,
   input  logic       tbl_wr,
   input  logic [1:0] tbl_wdata,
   output logic       en,
   output logic [1:0] tx_sel,
   output logic [1:0] rx_sel,
   output logic [1:0] tbl,
   output logic       tx_rst,
   output logic       rx_rst,
   output logic [7:0] rdata
);
   logic dma_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         tx_sel <= 2'd0;
         rx_sel <= 2'd0;
         tbl    <= 2'd0;
         dma_q  <= 1'b0;
         tx_rst <= 1'b0;
         rx_rst <= 1'b0;
      end else begin
         tx_rst <= ctl_wr & ctl_wdata[0] & ctl_wdata[2];
         rx_rst <= ctl_wr & ctl_wdata[0] & ctl_wdata[1];
         if (ctl_wr) begin
            en     <= ctl_wdata[0];
            tx_sel <= ctl_wdata[5:4];
            rx_sel <= ctl_wdata[7:6];
            if (ctl_wdata[0]) dma_q <= ctl_wdata[3];
         end
         if (tbl_wr) tbl <= tbl_wdata;
      end
   end

   assign rdata = {rx_sel, tx_sel, dma_q, tx_rst, rx_rst, en};

   AST_TX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |-> $past(ctl_wr && ctl_wdata[0] && ctl_wdata[2])); // R3
   AST_RX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |-> $past(ctl_wr && ctl_wdata[0] && ctl_wdata[1])); // R4
   AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[0]) |=> $stable(dma_q)); // R5
endmodule

// File: rtl/uft_level_lut.sv
module uft_level_lut #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             en,
   input  logic [1:0]       tbl,
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] level
);
   always_comb begin
      if (en) level = CNT_W'(uft_pkg::trig_level(tbl, sel));
      else    level = CNT_W'(1);
   end

   always_comb begin
      AST_LEVEL_ONE_WHEN_OFF: assert (en || level == CNT_W'(1)); // R8
   end
endmodule

// File: rtl/uft_irq_gen.sv
module uft_irq_gen #(
   parameter int unsigned CNT_W   = 7,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_level,
   input  logic [CNT_W-1:0] rx_level,
   input  logic             tx_rst,
   output logic             tx_irq,
   output logic             rx_irq
);
   logic above_q;
   logic tx_raw, rx_raw;

   // Record of the transmit count having exceeded its level since last empty
   always_ff @(posedge clk) begin
      if (!rst_n)                          above_q <= 1'b0;
      else if (tx_rst || tx_count == '0)   above_q <= 1'b0;
      else if (tx_count > tx_level)        above_q <= 1'b1;
   end

   assign tx_raw = above_q ? (tx_count < tx_level) : (tx_count == '0);
   assign rx_raw = (rx_count >= rx_level);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_irq <= 1'b0;
               rx_irq <= 1'b0;
            end else begin
               tx_irq <= tx_raw;
               rx_irq <= rx_raw;
            end
         end
      end else begin : g_comb
         assign tx_irq = tx_raw;
         assign rx_irq = rx_raw;

         AST_TX_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_count == '0) |-> tx_irq); // R10
         AST_TX_HOLD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_rst && tx_count != '0 && tx_count <= tx_level) |=>
            (tx_count == '0 || tx_count > $past(tx_count) || $past(tx_level) != tx_level || !tx_irq)); // R11
      end
   endgenerate
endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl #(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter bit          REG_OUT    = 1'b0,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic             tbl_wr,
   input  logic [1:0]       tbl_wdata,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output logic             tx_ptr_rst,
   output logic             rx_ptr_rst,
   output logic             tx_irq,
   output logic             rx_irq
);
   initial begin
      AST_DEPTH_FITS_TABLE: assert (FIFO_DEPTH >= uft_pkg::MAX_LEVEL); // R6
   end

   logic             en;
   logic [1:0]       tbl;
   logic [1:0]       sel   [2];
   logic [CNT_W-1:0] level [2];

   uft_ctl_reg u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .en(en), .tx_sel(sel[0]), .rx_sel(sel[1]), .tbl(tbl),
      .tx_rst(tx_ptr_rst), .rx_rst(rx_ptr_rst), .rdata(ctl_rdata)
   );

   // Index 0 = transmit, 1 = receive; one shared table index
   generate
      for (genvar d = 0; d < 2; d++) begin : g_dir
         uft_level_lut #(.CNT_W(CNT_W)) u_lut (
            .en(en), .tbl(tbl), .sel(sel[d]), .level(level[d])
         );
      end
   endgenerate

   uft_irq_gen #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_level(level[0]), .rx_level(level[1]),
      .tx_rst(tx_ptr_rst),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   AST_TX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(FIFO_DEPTH)); // R10
   AST_STROBES_EXCLUSIVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ptr_rst || rx_ptr_rst) |-> ctl_rdata[0]); // R3
endmodule

// File: tb/uart_fifo_trig_ctrl_bench.sv
module uart_fifo_trig_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic tbl_wr = 1'b0;
   logic [1:0] tbl_wdata = '0;
   logic [CW-1:0] tx_count = '0;
   logic [CW-1:0] rx_count = '0;
   logic tx_ptr_rst, rx_ptr_rst, tx_irq, rx_irq;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_trig_ctrl u_uart_fifo_trig_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_ptr_rst(tx_ptr_rst), .rx_ptr_rst(rx_ptr_rst),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   function automatic int exp_level(input int t, input int s);
      int tab [4][4] = '{'{1,4,8,14}, '{8,16,24,28}, '{8,16,32,56}, '{1,16,32,56}};
      return tab[t][s];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive a control write; returns at the negedge after the capturing edge
   task automatic ctl_write(input logic [7:0] v);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic tbl_write(input logic [1:0] v);
      @(negedge clk);
      tbl_wr = 1'b1; tbl_wdata = v;
      @(negedge clk);
      tbl_wr = 1'b0;
   endtask

   task automatic t_reset_state;
      check("R1 rdata", ctl_rdata, 0);
      check("R1 tx_ptr_rst", tx_ptr_rst, 0);
      check("R1 rx_ptr_rst", rx_ptr_rst, 0);
      check("R1 rx_irq", rx_irq, 0);
      check("R1 tx_irq", tx_irq, 1);
   endtask

   task automatic t_readback;
      ctl_write(8'b10_01_0_0_0_1);
      check("R2 readback", ctl_rdata, 8'h91);
   endtask

   task automatic t_tx_strobe;
      ctl_write(8'h05);
      check("R3 tx strobe high", tx_ptr_rst, 1);
      check("R3 readback bit2", ctl_rdata[2], 1);
      check("R3 rx strobe low", rx_ptr_rst, 0);
      @(negedge clk);
      check("R3 strobe one cycle", tx_ptr_rst, 0);
      check("R3 bit2 cleared", ctl_rdata[2], 0);
      ctl_write(8'h04);
      check("R3 no strobe when disabled", tx_ptr_rst, 0);
   endtask

   task automatic t_rx_strobe;
      ctl_write(8'h03);
      check("R4 rx strobe high", rx_ptr_rst, 1);
      check("R4 tx strobe low", tx_ptr_rst, 0);
      @(negedge clk);
      check("R4 strobe one cycle", rx_ptr_rst, 0);
      ctl_write(8'h02);
      check("R4 no strobe when disabled", rx_ptr_rst, 0);
   endtask

   task automatic t_dma;
      ctl_write(8'h09);
      check("R5 dma set", ctl_rdata[3], 1);
      ctl_write(8'h00);
      check("R5 dma kept when disabled", ctl_rdata[3], 1);
      ctl_write(8'h01);
      check("R5 dma cleared", ctl_rdata[3], 0);
   endtask

   // Receive level probe: one below the level and at it
   task automatic t_rx_tables;
      for (int t = 0; t < 4; t++) begin
         tbl_write(2'(t));
         for (int s = 0; s < 4; s++) begin
            ctl_write({2'(s), 2'b00, 4'b0001});
            rx_count = CW'(exp_level(t, s) - 1);
            #1 check("R6 R9 rx below level", rx_irq, 0);
            rx_count = CW'(exp_level(t, s));
            #1 check("R6 R9 rx at level", rx_irq, 1);
         end
      end
      rx_count = '0;
   endtask

   task automatic t_shared_table;
      ctl_write(8'b10_10_0001);  // both selects = 2
      tbl_write(2'd1);           // level 24 both sides
      rx_count = 7'd23;
      #1 check("R7 rx table1", rx_irq, 0);
      tbl_write(2'd2);           // level 32
      rx_count = 7'd31;
      #1 check("R7 rx table2", rx_irq, 0);
      rx_count = 7'd32;
      #1 check("R7 rx table2 at", rx_irq, 1);
      // transmit side follows the same table: fill to 33 then drop to 31
      tx_count = 7'd33;
      @(negedge clk);
      tx_count = 7'd31;
      #1 check("R7 tx table2 below", tx_irq, 1);
      tx_count = 7'd32;
      #1 check("R7 tx table2 at", tx_irq, 0);
      tx_count = '0; rx_count = '0;
      @(negedge clk);
   endtask

   task automatic t_disabled_level;
      tbl_write(2'd2);
      ctl_write(8'hF0);          // enable 0, selects 3
      rx_count = 7'd1;
      #1 check("R8 rx level one", rx_irq, 1);
      rx_count = 7'd0;
      #1 check("R8 rx empty", rx_irq, 0);
      tx_count = 7'd2;
      @(negedge clk);
      tx_count = 7'd1;
      #1 check("R8 tx level one", tx_irq, 0);
      tx_count = 7'd0;
      #1 check("R8 tx empty", tx_irq, 1);
      @(negedge clk);
   endtask

   task automatic t_tx_rules;
      tbl_write(2'd0);
      ctl_write(8'b00_10_0001);  // tx level 8
      tx_count = 7'd0;
      #1 check("R10 tx empty", tx_irq, 1);
      @(negedge clk);
      tx_count = 7'd3;
      #1 check("R11 low reload", tx_irq, 0);
      @(negedge clk);
      tx_count = 7'd8;
      #1 check("R11 at level not above", tx_irq, 0);
      @(negedge clk);
      tx_count = 7'd0;
      #1 check("R10 empties", tx_irq, 1);
      @(negedge clk);
      tx_count = 7'd12;
      @(negedge clk);
      tx_count = 7'd7;
      #1 check("R10 below after above", tx_irq, 1);
      tx_count = 7'd8;
      #1 check("R10 at level after above", tx_irq, 0);
      @(negedge clk);
      tx_count = 7'd0;
      @(negedge clk);
      tx_count = 7'd5;
      #1 check("R11 cleared on empty", tx_irq, 0);
      @(negedge clk);
      // pointer reset clears the above record
      tx_count = 7'd12;
      @(negedge clk);
      ctl_write(8'b00_10_0101);
      tx_count = 7'd5;
      @(negedge clk);
      check("R11 cleared by tx reset", tx_irq, 0);
      tx_count = '0;
      @(negedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset_state();
            t_readback();
            t_tx_strobe();
            t_rx_strobe();
            t_dma();
            t_rx_tables();
            t_shared_table();
            t_disabled_level();
            t_tx_rules();
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule